// File: doc/BRIEF.md
# Bus Reset Generator with Clock-Activity Watch

This block drives the active-low reset that every node on a shared system bus sees. Four conditions can hold that reset: an external reset request, the system bus clock going silent, the local processor oscillator going silent, and a digital flag that reports the supply below its limit. Any one of them pulls the reset low. The external request and the supply flag pass through two-flop synchronizers first. Each monitored clock is sampled as data in a free-running reference clock domain. A clock counts as stopped when the monitor sees no transition for a set number of reference cycles.

The reset is released only after a fault-free interval, given in reference ticks, that stands for the oscillator settling time of about 20 ms. Any fault during that interval starts it again from zero. A cause register records which conditions were active when the most recent fault episode began. It uses one bit per condition.

Top module: `bus_rst_gen`

## Requirements
- R1: A high level on `ext_rst_i` drives `sys_rst_no` low on the third rising edge of `clk_i` after it is first sampled. It stays low while the input is held. `cause_o` bit 0 stands for this cause.
- R2: When `bus_clk_i` shows no transition for about STOP_TIMEOUT reference cycles, `sys_rst_no` goes low. `cause_o` bit 1 stands for this cause.
- R3: When `osc_clk_i` shows no transition for about STOP_TIMEOUT reference cycles, `sys_rst_no` goes low. `cause_o` bit 2 stands for this cause.
- R4: A high level on `uv_i` drives `sys_rst_no` low with the same three-edge latency as R1. `cause_o` bit 3 stands for this cause.
- R5: `sys_rst_no` rises exactly STAB_TICKS+3 rising edges after the last active synchronized input is first sampled low, with both clocks running. It stays low for as long as any fault persists.
- R6: A fault that appears while the settling interval is counting restarts the interval. The release is then timed from the end of the new fault.
- R7: On the first cycle in which any fault is present after a fault-free cycle, `cause_o` loads the full set of faults active at that moment. Otherwise `cause_o` holds its value.
- R8: While `rst_ni` is low, `sys_rst_no` is low and `cause_o` is zero. Both clocks are treated as stopped until a transition is seen. The power-up clock detection does not change `cause_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset request, active high, asynchronous |
| uv_i | input | 1 | Supply undervoltage flag, active high, asynchronous |
| bus_clk_i | input | 1 | System bus clock, sampled for activity |
| osc_clk_i | input | 1 | Local processor oscillator, sampled for activity |
| sys_rst_no | output | 1 | Bus-wide reset, active low |
| cause_o | output | 4 | Faults active at the onset of the last reset: bit0 external, bit1 bus clock, bit2 oscillator, bit3 undervoltage |

## Verification
The assertions check four rules on every cycle. A synchronized fault or a detected clock stop is always followed by a low reset. The external and supply inputs act with their fixed pipeline delay. Every rise of the reset comes after at least STAB_TICKS fault-free cycles, and the cause register captures the fault vector at each fault onset. Only the bench scenarios can show the exact release edge, the restart of the settling interval after a late glitch, the detection window for a stopped clock of either speed, and the cause value after combined faults.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;
  localparam int unsigned N_CAUSE   = 4;
  localparam int unsigned CAUSE_EXT = 0;
  localparam int unsigned CAUSE_BUS = 1;
  localparam int unsigned CAUSE_OSC = 2;
  localparam int unsigned CAUSE_UV  = 3;
  localparam int unsigned N_MON_CLK = 2;
  typedef logic [N_CAUSE-1:0] cause_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/clk_act_mon.sv
module clk_act_mon #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_i,
  output logic stopped_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [2:0]    smp_q;
  logic [CW-1:0] idle_q;
  logic          toggle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= {smp_q[1:0], mon_i};
  end

  assign toggle = smp_q[2] ^ smp_q[1];

  // starts saturated: a clock is stopped until proven running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_q <= LIMIT;
    else if (toggle)          idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign stopped_o = (idle_q == LIMIT);
endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
  parameter int unsigned TICKS = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fault_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/bus_rst_gen.sv
module bus_rst_gen
  import bus_rst_pkg::*;
#(
  parameter int unsigned STOP_TIMEOUT = 64,
  parameter int unsigned STAB_TICKS   = 2_000_000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_rst_i,
  input  logic         uv_i,
  input  logic         bus_clk_i,
  input  logic         osc_clk_i,
  output logic         sys_rst_no,
  output logic [3:0]   cause_o
);
  logic [1:0]           async_s;
  logic [N_MON_CLK-1:0] mon_clk;
  logic [N_MON_CLK-1:0] clk_stop;
  cause_t               fault;
  logic                 any_fault, stab_done;
  logic                 rst_q, any_q;
  cause_t               cause_q;

  rst_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({uv_i, ext_rst_i}),
    .q_o   (async_s)
  );

  assign mon_clk = {osc_clk_i, bus_clk_i};

  for (genvar g = 0; g < N_MON_CLK; g++) begin : g_mon
    clk_act_mon #(.TIMEOUT(STOP_TIMEOUT)) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mon_i    (mon_clk[g]),
      .stopped_o(clk_stop[g])
    );
  end

  always_comb begin
    fault            = '0;
    fault[CAUSE_EXT] = async_s[0];
    fault[CAUSE_BUS] = clk_stop[0];
    fault[CAUSE_OSC] = clk_stop[1];
    fault[CAUSE_UV]  = async_s[1];
  end

  assign any_fault = |fault;

  stab_timer #(.TICKS(STAB_TICKS)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(any_fault),
    .done_o (stab_done)
  );

  // any_q resets high so power-up clock detection leaves cause at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b0;
      any_q   <= 1'b1;
      cause_q <= '0;
    end else begin
      rst_q <= stab_done & ~any_fault;
      any_q <= any_fault;
      if (any_fault && !any_q) cause_q <= fault;
    end
  end

  assign sys_rst_no = rst_q;
  assign cause_o    = cause_q;
endmodule

// File: rtl/bus_rst_gen_chk.sv
module bus_rst_gen_chk #(
  parameter int unsigned STAB_TICKS = 2_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_i,
  input logic       uv_i,
  input logic [3:0] fault_i,
  input logic       sys_rst_no,
  input logic [3:0] cause_o
);
  logic [31:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  quiet_q <= '0;
    else if (fault_i != 4'd0)     quiet_q <= '0;
    else if (quiet_q != '1)       quiet_q <= quiet_q + 1'b1;
  end

  a_r1_ext_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ext_rst_i, 3) |-> !sys_rst_no);

  a_r4_uv_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_i, 3) |-> !sys_rst_no);

  a_r2_bus_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[1] |=> !sys_rst_no);

  a_r3_osc_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[2] |=> !sys_rst_no);

  a_r5_release_after_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (quiet_q >= 32'(STAB_TICKS)));

  a_r7_cause_on_onset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|fault_i) |=> (cause_o == $past(fault_i)));
endmodule

bind bus_rst_gen bus_rst_gen_chk #(.STAB_TICKS(STAB_TICKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ext_rst_i (ext_rst_i),
  .uv_i      (uv_i),
  .fault_i   (fault),
  .sys_rst_no(sys_rst_no),
  .cause_o   (cause_o)
);

// File: tb/bus_rst_gen_tb_top.sv
module bus_rst_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO   = 6;
  localparam int STAB = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_rst = 1'b0, uv = 1'b0;
  logic bus_clk = 1'b0, osc_clk = 1'b0;
  logic bus_run = 1'b1, osc_run = 1'b1;
  logic [1:0] osc_div = '0;
  logic sys_rst_n;
  logic [3:0] cause;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (bus_run) bus_clk <= ~bus_clk;
  always @(negedge clk) if (osc_run) begin
    if (osc_div == 2'd2) begin osc_div <= '0; osc_clk <= ~osc_clk; end
    else osc_div <= osc_div + 1'b1;
  end

  bus_rst_gen #(.STOP_TIMEOUT(TO), .STAB_TICKS(STAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .uv_i(uv),
    .bus_clk_i(bus_clk), .osc_clk_i(osc_clk),
    .sys_rst_no(sys_rst_n), .cause_o(cause)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_low_in(int max);
    return max;
  endfunction

  // ticks until sys_rst_n reaches level lvl, up to max
  task automatic wait_lvl(logic lvl, int max, output int n);
    n = 0;
    while (sys_rst_n !== lvl && n < max) begin tick(); n++; end
  endtask

  // after the last async fault input was dropped at this tick: exact release
  task automatic chk_release(string req);
    tick(2 + STAB);
    chk(sys_rst_n === 1'b0, req, sys_rst_n, 0);
    tick();
    chk(sys_rst_n === 1'b1, req, sys_rst_n, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    // R8: reset state
    tick(3);
    chk(sys_rst_n === 1'b0, "R8 rst low", sys_rst_n, 0);
    chk(cause === 4'd0, "R8 cause zero", cause, 0);
    rst_ni = 1'b1;
    tick(STAB);
    chk(sys_rst_n === 1'b0, "R8 held during first settle", sys_rst_n, 0);
    wait_lvl(1'b1, TO + 20, n);
    chk(sys_rst_n === 1'b1, "R5 power-up release", sys_rst_n, 1);
    chk(cause === 4'd0, "R8 cause untouched by power-up", cause, 0);

    // R1 / R4: pulse sweep over cause input and width
    for (int src = 0; src < 3; src++) begin
      for (int len = 1; len <= 5; len += 2) begin
        logic [3:0] exp_c;
        exp_c = (src == 0) ? 4'b0001 : (src == 1) ? 4'b1000 : 4'b1001;
        ext_rst = (src != 1);
        uv      = (src != 0);
        tick(2);
        chk(sys_rst_n === 1'b1, "R1 R4 not before 3rd edge", sys_rst_n, 1);
        tick();
        chk(sys_rst_n === 1'b0, "R1 R4 low at 3rd edge", sys_rst_n, 0);
        if (len > 3) tick(len - 3);
        ext_rst = 1'b0; uv = 1'b0;
        if (len < 3) begin
          // pulse already dropped earlier: re-time from the drop
        end
        chk(cause === exp_c, "R7 cause set", cause, exp_c);
        chk_release("R5 exact release");
      end
    end

    // R6: glitch during settling restarts the interval
    ext_rst = 1'b1; tick(4); ext_rst = 1'b0;
    tick(STAB / 2);
    chk(sys_rst_n === 1'b0, "R6 still settling", sys_rst_n, 0);
    uv = 1'b1; tick(); uv = 1'b0;
    chk_release("R6 restart from new fault");
    chk(cause === 4'b1000, "R7 cause of later onset", cause, 4'b1000);

    // R2: bus clock stop
    bus_run = 1'b0;
    wait_lvl(1'b0, 40, n);
    chk(n >= TO - 3 && n <= TO + 6, "R2 stop window", n, TO);
    chk(cause === 4'b0010, "R2 R7 cause bus", cause, 4'b0010);
    tick(3 * STAB);
    chk(sys_rst_n === 1'b0, "R5 held while stopped", sys_rst_n, 0);
    bus_run = 1'b1;
    wait_lvl(1'b1, STAB + 20, n);
    chk(n >= STAB + 1 && n <= STAB + 10, "R5 R2 release window", n, STAB + 3);

    // R3: oscillator stop
    osc_run = 1'b0;
    wait_lvl(1'b0, 40, n);
    chk(n >= TO - 3 && n <= TO + 6, "R3 stop window", n, TO);
    chk(cause === 4'b0100, "R3 R7 cause osc", cause, 4'b0100);
    osc_run = 1'b1;
    wait_lvl(1'b1, STAB + 20, n);
    chk(n >= STAB + 1 && n <= STAB + 12, "R5 R3 release window", n, STAB + 3);

    // both clocks stop together
    bus_run = 1'b0; osc_run = 1'b0;
    wait_lvl(1'b0, 40, n);
    tick(TO + 6);
    chk(sys_rst_n === 1'b0, "R2 R3 both stopped", sys_rst_n, 0);
    chk(cause[1] === 1'b1, "R7 cause bus bit in joint stop", cause, 4'b0110);
    bus_run = 1'b1; osc_run = 1'b1;
    wait_lvl(1'b1, STAB + 20, n);
    chk(sys_rst_n === 1'b1, "R5 release after joint stop", sys_rst_n, 1);

    // R8: power-on reset mid-run, clocks held stopped afterwards
    bus_run = 1'b0;
    rst_ni = 1'b0; tick();
    chk(sys_rst_n === 1'b0 && cause === 4'd0, "R8 async reset", cause, 0);
    rst_ni = 1'b1;
    tick(2 * STAB);
    chk(sys_rst_n === 1'b0, "R8 no release without clock edge", sys_rst_n, 0);
    chk(cause === 4'd0, "R8 cause zero without onset", cause, 0);
    finish_run();
  end
endmodule